// File: doc/BRIEF.md
# Iterative Shift-Subtract Divider and Square Root Unit

This block is a compact sequential arithmetic engine. It computes either the unsigned quotient and remainder of two 16-bit operands, or the integer square root of one 16-bit operand together with what is left over. Both functions share one shift-subtract datapath. The block handles one operation at a time. It is deliberately not pipelined: it spends a fixed number of cycles on each operation so that it needs only a single narrow subtractor.

A client places its operands and a function select on the inputs and raises `start_i` for one cycle while the unit is idle. `busy_o` then stays high while the iterations run. A single-cycle `done_o` pulse marks the cycle in which the results become valid. The results stay on the outputs until another operation is accepted. A divide with a zero divisor follows a defined convention and is also flagged.

Top module: `shsub_divroot`

## Requirements
- R1: With `mode_i` = 0 (divide) and a nonzero divisor `opb_i`, `quot_o` equals floor(`opa_i` / `opb_i`) and `rem_o` equals `opa_i` mod `opb_i`, so that `rem_o` is less than the divisor.
- R2: With `mode_i` = 1 (square root), `quot_o` equals floor(sqrt(`opa_i`)) in its low 8 bits with its upper 8 bits zero, and `rem_o` equals `opa_i` minus the square of that root.
- R3: A divide with `opb_i` = 0 gives `quot_o` = 0xFFFF and `rem_o` = `opa_i`, and `dz_o` is high when `done_o` pulses. `dz_o` is low at completion of every other operation.
- R4: If `start_i` is sampled at rising edge 0, `done_o` is high for exactly the cycle that follows rising edge 16 for a divide, or rising edge 8 for a square root, and it is low in the cycles before that.
- R5: `busy_o` is high from the cycle after the accepted start up to, but not including, the `done_o` cycle. `busy_o` and `done_o` are never high together.
- R6: A `start_i` raised while `busy_o` is high is ignored: the running operation finishes with its original result and timing, and no second operation follows.
- R7: While `busy_o` is low and no start is sampled, `quot_o`, `rem_o` and `dz_o` keep their values.
- R8: A start presented in the `done_o` cycle is accepted, so operations can run back to back.
- R9: While reset is active, and in the first cycle after it ends, `busy_o`, `done_o` and `dz_o` are low and `quot_o` and `rem_o` are zero.
- R10: In square-root mode `opb_i` has no effect: a zero `opb_i` raises no divide-by-zero flag and leaves the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request an operation; sampled only while idle |
| mode_i | input | 1 | 0 = divide, 1 = square root |
| opa_i | input | 16 | Dividend, or radicand for square root |
| opb_i | input | 16 | Divisor; unused in square-root mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | Last accepted divide had a zero divisor |
| quot_o | output | 16 | Quotient, or root in the low 8 bits |
| rem_o | output | 16 | Remainder of the divide or of the square root |

## Verification
Divides are tried with a small dividend over a prime divisor, and with the extremes: all-ones by one, equal operands, a dividend below the divisor, and a zero dividend. Together these show whether each of the 16 quotient bits and the restore decision are right at both ends of the range. Square roots are taken of zero, one, perfect squares, values just below a square, and the full-scale operand; these expose off-by-one root bits and a wrong trial subtrahend. A zero divisor, a zero second operand in root mode, a start during a run, and a start in the done cycle tell the flag logic and the handshake apart from the arithmetic.

// File: rtl/divroot_pkg.sv
package divroot_pkg;
  typedef enum logic {
    OP_DIV  = 1'b0,
    OP_ROOT = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/divroot_rstsync.sv
module divroot_rstsync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/divroot_ctrl.sv
module divroot_ctrl
  import divroot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic mode_i,
  input  logic divisor_zero_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic root_o,
  output logic dz_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] DIV_STEPS  = CNT_W'(W);
  localparam logic [CNT_W-1:0] ROOT_STEPS = CNT_W'(W / 2);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;
  logic             root_q;
  logic             dz_q;
  logic             load;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load  = 1'b1;
          st_d  = ST_RUN;
          cnt_d = (mode_i == OP_ROOT) ? ROOT_STEPS : DIV_STEPS;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= finish_o;
    end
  end

  // operation attributes, captured only when an operation is accepted
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      root_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (load) begin
      root_q <= mode_i;
      dz_q   <= (mode_i == OP_DIV) && divisor_zero_i;
    end
  end

  assign busy_o   = (st_q == ST_RUN);
  assign load_o   = load;
  assign step_o   = busy_o;
  assign finish_o = busy_o && (cnt_q == ONE);
  assign root_o   = root_q;
  assign dz_o     = dz_q;
  assign done_o   = done_q;

  // R6: a start during a run does not restart the iteration count
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && start_i && !finish_o) |=> (busy_o && cnt_q == $past(cnt_q) - ONE));

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);

  // R4: an accepted operation never completes on the next edge
  a_r4_no_early_finish: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_o |=> (busy_o && !finish_o));

  // R5: busy and done are exclusive
  a_r5_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> !busy_o);
endmodule

// File: rtl/divroot_datapath.sv
module divroot_datapath #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         root_i,
  input  logic         finish_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] rem_o
);
  localparam int TW = W + 1;

  logic [W-1:0]  src_q, src_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dsr_q;
  logic [TW-1:0] partial;
  logic [TW-1:0] subtrahend;
  logic [TW:0]   trial;
  logic          fits;
  logic          upd;

  // shared shift-subtract step; the mode only selects the operand alignment
  always_comb begin
    if (root_i) begin
      partial    = {rem_q[W-2:0], src_q[W-1:W-2]};
      subtrahend = {acc_q[W-2:0], 2'b01};
      src_d      = {src_q[W-3:0], 2'b00};
    end else begin
      partial    = {rem_q, src_q[W-1]};
      subtrahend = {1'b0, dsr_q};
      src_d      = {src_q[W-2:0], 1'b0};
    end
    trial = {1'b0, partial} - {1'b0, subtrahend};
    fits  = !trial[TW];
    rem_d = fits ? trial[W-1:0] : partial[W-1:0];
    acc_d = {acc_q[W-2:0], fits};
  end

  assign upd = load_i || step_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q <= '0;
      acc_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
    end else if (upd) begin
      if (load_i) begin
        src_q <= opa_i;
        acc_q <= '0;
        rem_q <= '0;
        dsr_q <= opb_i;
      end else begin
        src_q <= src_d;
        acc_q <= acc_d;
        rem_q <= rem_d;
      end
    end
  end

  assign acc_o = acc_q;
  assign rem_o = rem_q;

  // R1: a completed nonzero divide leaves a remainder below the divisor
  a_r1_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (finish_i && !root_i && dsr_q != '0) |=> (rem_q < dsr_q));

  // R2: a completed root leaves a remainder no larger than twice the root
  a_r2_root_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (finish_i && root_i) |=> ({1'b0, rem_q} <= {acc_q, 1'b0}));
endmodule

// File: rtl/shsub_divroot.sv
module shsub_divroot #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic rst_n;
  logic load;
  logic step;
  logic finish;
  logic root;

  divroot_rstsync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  divroot_ctrl #(.W(W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_n_i        (rst_n),
    .start_i        (start_i),
    .mode_i         (mode_i),
    .divisor_zero_i (opb_i == '0),
    .busy_o         (busy_o),
    .load_o         (load),
    .step_o         (step),
    .finish_o       (finish),
    .root_o         (root),
    .dz_o           (dz_o),
    .done_o         (done_o)
  );

  divroot_datapath #(.W(W)) u_dp (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .load_i   (load),
    .step_i   (step),
    .root_i   (root),
    .finish_i (finish),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .acc_o    (quot_o),
    .rem_o    (rem_o)
  );

  // R3: a flagged divide completes with an all-ones quotient
  a_r3_dz_quot_ones: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && dz_o) |-> (quot_o == '1));

  // R7: outputs hold while idle and no start is taken
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(rem_o) && $stable(dz_o)));

  // R10: root mode never raises the divide-by-zero flag
  a_r10_root_no_dz: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && root) |-> !dz_o);
endmodule

// File: tb/shsub_divroot_tb_top.sv
`timescale 1ns/1ps
module shsub_divroot_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         mode;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         busy;
  logic         done;
  logic         dz;
  logic [W-1:0] quot;
  logic [W-1:0] rem;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shsub_divroot #(.W(W)) dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .start_i (start),
    .mode_i  (mode),
    .opa_i   (opa),
    .opb_i   (opb),
    .busy_o  (busy),
    .done_o  (done),
    .dz_o    (dz),
    .quot_o  (quot),
    .rem_o   (rem)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int isqrt(input int a);
    int r = 0;
    while ((r + 1) * (r + 1) <= a) r++;
    return r;
  endfunction

  // drive an operation at a negedge; start is sampled at the following edge
  task automatic issue(input bit m, input int a, input int b);
    mode  = m;
    opa   = W'(a);
    opb   = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // called one negedge after the start edge; ends at the done negedge
  task automatic expect_op(input string req, input bit m, input int a, input int b);
    int n     = m ? W / 2 : W;
    int eq, er;
    bit eflag = 1'b0;
    bit early = 1'b0;
    bit nobusy = 1'b0;
    if (m) begin
      eq = isqrt(a);
      er = a - eq * eq;
    end else if (b == 0) begin
      eq = 65535;
      er = a;
      eflag = 1'b1;
    end else begin
      eq = a / b;
      er = a % b;
    end
    if (!busy) nobusy = 1'b1;
    for (int i = 1; i < n; i++) begin
      if (done) early = 1'b1;
      @(negedge clk);
      if (!busy) nobusy = 1'b1;
    end
    if (done) early = 1'b1;
    @(negedge clk);
    chk(!early && !nobusy, {req, " R5 busy during run, R4 no early done"}, int'(early), 0);
    chk(done === 1'b1 && busy === 1'b0, {req, " R4 done on final edge"}, int'(done), 1);
    chk(int'(quot) == eq, {req, " quotient/root"}, int'(quot), eq);
    chk(int'(rem) == er, {req, " remainder"}, int'(rem), er);
    chk(dz === eflag, {req, " R3 flag"}, int'(dz), int'(eflag));
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0 && dz === 1'b0, "R9 reset controls", int'(busy), 0);
    chk(quot === '0 && rem === '0, "R9 reset outputs", int'(quot), 0);
  endtask

  task automatic t_divide();
    issue(1'b0, 100, 7);      expect_op("R1 100/7", 1'b0, 100, 7);
    issue(1'b0, 65535, 1);    expect_op("R1 max/1", 1'b0, 65535, 1);
    issue(1'b0, 5, 9);        expect_op("R1 small/large", 1'b0, 5, 9);
    issue(1'b0, 65535, 65535); expect_op("R1 equal", 1'b0, 65535, 65535);
    issue(1'b0, 0, 5);        expect_op("R1 zero dividend", 1'b0, 0, 5);
    issue(1'b0, 40000, 255);  expect_op("R1 40000/255", 1'b0, 40000, 255);
    issue(1'b0, 65535, 32768); expect_op("R1 top divisor", 1'b0, 65535, 32768);
  endtask

  task automatic t_divzero();
    issue(1'b0, 1234, 0);     expect_op("R3 1234/0", 1'b0, 1234, 0);
    issue(1'b0, 65535, 0);    expect_op("R3 max/0", 1'b0, 65535, 0);
  endtask

  task automatic t_root();
    issue(1'b1, 0, 0);        expect_op("R2 R10 sqrt 0", 1'b1, 0, 0);
    issue(1'b1, 1, 0);        expect_op("R2 sqrt 1", 1'b1, 1, 0);
    issue(1'b1, 2, 77);       expect_op("R2 R10 sqrt 2", 1'b1, 2, 77);
    issue(1'b1, 15, 0);       expect_op("R2 sqrt 15", 1'b1, 15, 0);
    issue(1'b1, 16, 0);       expect_op("R2 sqrt 16", 1'b1, 16, 0);
    issue(1'b1, 50000, 3);    expect_op("R2 sqrt 50000", 1'b1, 50000, 3);
    issue(1'b1, 65535, 0);    expect_op("R2 sqrt max", 1'b1, 65535, 0);
  endtask

  task automatic t_back_to_back();
    issue(1'b0, 999, 10);     expect_op("R8 first", 1'b0, 999, 10);
    issue(1'b1, 1000, 0);     expect_op("R8 second", 1'b1, 1000, 0);
    issue(1'b0, 7, 0);        expect_op("R8 third", 1'b0, 7, 0);
  endtask

  task automatic t_start_while_busy();
    bit early = 1'b0;
    issue(1'b0, 1000, 3);                       // now past edge 0
    repeat (3) @(negedge clk);                  // past edge 3
    mode = 1'b1; opa = 16'd81; opb = 16'd0; start = 1'b1;
    @(negedge clk);                             // edge 4 sees start while busy
    start = 1'b0;
    for (int i = 5; i < 16; i++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    if (done) early = 1'b1;
    @(negedge clk);                             // past edge 16
    chk(!early && done === 1'b1, "R6 original timing", int'(done), 1);
    chk(quot == 16'd333 && rem == 16'd1, "R6 original result", int'(quot), 333);
    chk(dz === 1'b0, "R6 no flag from ignored start", int'(dz), 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R6 no queued operation", int'(busy), 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    logic         d0;
    bit           moved = 1'b0;
    issue(1'b0, 4321, 0);     expect_op("R7 setup", 1'b0, 4321, 0);
    q0 = quot; r0 = rem; d0 = dz;
    for (int i = 0; i < 6; i++) begin
      mode = i[0]; opa = W'(i * 911); opb = W'(i + 3);
      @(negedge clk);
      if (quot !== q0 || rem !== r0 || dz !== d0 || busy || done) moved = 1'b1;
    end
    chk(!moved, "R7 outputs held while idle", int'(quot), int'(q0));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && quot === '0, "R9 during reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_divide();
    t_divzero();
    t_root();
    t_back_to_back();
    t_start_while_busy();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule